// File: doc/BRIEF.md
# Burst Ready Generator

This block decides, every moment, whether the processor bus sees an active-low burst-ready strobe from the cache-tag side. It combines the tag comparator's hit result, the stored valid and write-through status bits, the processor write/read line and a status-mode select. It also takes a force-high override and an external burst-ready request that is sampled on the clock. The tag storage itself lives elsewhere. The block receives the stored bits and a summary of tag and status activity and array clearing as plain inputs.

Apart from the external request register, the output path is purely combinational. This lets a cache controller get a hit decision in the same cycle the address and tag are presented. Pad tri-stating is modelled as a drive flag. While the flag is low the strobe value is parked high. The drive flag falls when the strobe's own output enable is inactive or the part is deselected. The part is selected only when every active-low select is low and every active-high select is high. The number of each kind of select is a parameter. All pins are plain control and status pins, so there is no valid/ready handshake and no back-pressure.

Top module: `burst_ready_gen`

## Requirements
- R1: `rdy_drv` is 1 exactly when `rdy_oe_n` is 0, every bit of `cs_lo_n` is 0 and every bit of `cs_hi` is 1; whenever `rdy_drv` is 0, `rdy_n` reads 1.
- R2: `ext_rdy_n` is captured on rising clock edges through `EXT_STAGES` registers. Once a 0 has passed all stages, a driven `rdy_n` is 0 regardless of every other input. A change of `ext_rdy_n` between edges has no effect until the `EXT_STAGES`-th following edge.
- R3: While `rst_n` is 0 the capture registers hold 1 (no request), so a low `ext_rdy_n` held through reset has no effect on `rdy_n` after reset release until it has been sampled `EXT_STAGES` times.
- R4: With no sampled external request, `force_hi` = 1 makes a driven `rdy_n` 1.
- R5: With no sampled request, any of `tag_rd`, `tag_wr`, `stat_wr` or `clr_act` at 1 makes a driven `rdy_n` 1.
- R6: In dedicated mode (`generic_mode` = 0), with no request, override or activity, `cpu_wr` = 1 together with `wt` = 1 makes `rdy_n` 1. With `cpu_wr` = 0 the compare result applies again.
- R7: In dedicated mode, with no request, override, activity or write-through write, `vld` = 0 makes `rdy_n` 1.
- R8: In dedicated mode, when no higher rule applies, `rdy_n` is 0 when `hit` = 1 and `vld` = 1, and 1 otherwise.
- R9: In generic mode (`generic_mode` = 1), `vld`, `wt` and `cpu_wr` have no effect; with no request, override or activity, `rdy_n` equals the inverse of `hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the external-request capture |
| rst_n | input | 1 | Asynchronous active-low reset of the capture registers |
| cs_lo_n | input | N_LO | Active-low chip selects |
| cs_hi | input | N_HI | Active-high chip selects |
| rdy_oe_n | input | 1 | Active-low output enable of the strobe |
| ext_rdy_n | input | 1 | External burst-ready request, active low, synchronous |
| force_hi | input | 1 | Override that holds the strobe inactive |
| tag_rd | input | 1 | Tag read in progress |
| tag_wr | input | 1 | Tag write in progress |
| stat_wr | input | 1 | Status write in progress |
| clr_act | input | 1 | Status array clear in progress |
| cpu_wr | input | 1 | Processor cycle type, 1 = write, 0 = read |
| generic_mode | input | 1 | 0 = status bits carry valid/write-through meaning, 1 = user-defined |
| hit | input | 1 | Tag comparator equality result |
| vld | input | 1 | Stored valid bit at the addressed entry |
| wt | input | 1 | Stored write-through bit at the addressed entry |
| rdy_n | output | 1 | Burst-ready strobe, active low |
| rdy_drv | output | 1 | 1 when the strobe pin is driven, 0 when released |

## Verification
The bench builds the block with two active-low selects, one active-high select and a two-register capture chain. The second select proves that selection needs every select bit. The deeper chain shows latency counted in edges rather than a single sample. With these values the remaining fourteen combinational inputs span 16384 patterns. Each pattern is swept against both settled request levels, so every priority crossing is reached. Separate sequences cover the edge-by-edge arrival and withdrawal of a request and the behaviour across reset release.

// File: rtl/brdy_pkg.sv
package brdy_pkg;

  // Winning rule of the priority chain, highest first.
  typedef enum logic [2:0] {
    SRC_OFF   = 3'd0,
    SRC_EXT   = 3'd1,
    SRC_FORCE = 3'd2,
    SRC_BUSY  = 3'd3,
    SRC_WTHRU = 3'd4,
    SRC_INVAL = 3'd5,
    SRC_HIT   = 3'd6,
    SRC_MISS  = 3'd7
  } rdy_src_e;

  typedef struct packed {
    logic force_hi;
    logic busy;
    logic dedicated;
    logic cpu_wr;
    logic hit;
    logic vld;
    logic wt;
  } rdy_req_t;

  function automatic logic src_is_low(rdy_src_e s);
    return (s == SRC_EXT) || (s == SRC_HIT);
  endfunction

endpackage

// File: rtl/brdy_ext_sampler.sv
module brdy_ext_sampler #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_n,
  output logic ext_low
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b1;
        else        q <= ext_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], ext_n};
      end
    end
  endgenerate

  assign ext_low = ~q[LAST];
endmodule

// File: rtl/brdy_chip_sel.sv
module brdy_chip_sel #(
  parameter int N_LO = 1,
  parameter int N_HI = 1
) (
  input  logic [N_LO-1:0] cs_lo_n,
  input  logic [N_HI-1:0] cs_hi,
  input  logic            oe_n,
  output logic            drive
);
  logic [N_LO-1:0] lo_ok;
  logic [N_HI-1:0] hi_ok;

  generate
    for (genvar i = 0; i < N_LO; i++) begin : g_lo
      assign lo_ok[i] = ~cs_lo_n[i];
    end
    for (genvar j = 0; j < N_HI; j++) begin : g_hi
      assign hi_ok[j] = cs_hi[j];
    end
  endgenerate

  assign drive = ~oe_n & (&lo_ok) & (&hi_ok);
endmodule

// File: rtl/brdy_arbiter.sv
module brdy_arbiter
  import brdy_pkg::*;
(
  input  logic     drive,
  input  logic     ext_low,
  input  rdy_req_t req,
  output rdy_src_e src
);
  always_comb begin
    if (!drive)                                  src = SRC_OFF;
    else if (ext_low)                            src = SRC_EXT;
    else if (req.force_hi)                       src = SRC_FORCE;
    else if (req.busy)                           src = SRC_BUSY;
    else if (req.dedicated && req.cpu_wr && req.wt) src = SRC_WTHRU;
    else if (req.dedicated && !req.vld)          src = SRC_INVAL;
    else if (req.hit)                            src = SRC_HIT;
    else                                         src = SRC_MISS;
  end
endmodule

// File: rtl/burst_ready_gen.sv
module burst_ready_gen
  import brdy_pkg::*;
#(
  parameter int N_LO       = 1,
  parameter int N_HI       = 1,
  parameter int EXT_STAGES = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_LO-1:0] cs_lo_n,
  input  logic [N_HI-1:0] cs_hi,
  input  logic            rdy_oe_n,
  input  logic            ext_rdy_n,
  input  logic            force_hi,
  input  logic            tag_rd,
  input  logic            tag_wr,
  input  logic            stat_wr,
  input  logic            clr_act,
  input  logic            cpu_wr,
  input  logic            generic_mode,
  input  logic            hit,
  input  logic            vld,
  input  logic            wt,
  output logic            rdy_n,
  output logic            rdy_drv
);
  logic     drive;
  logic     ext_low;
  rdy_req_t req;
  rdy_src_e src;

  brdy_ext_sampler #(.STAGES(EXT_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_rdy_n), .ext_low(ext_low)
  );

  brdy_chip_sel #(.N_LO(N_LO), .N_HI(N_HI)) u_sel (
    .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .oe_n(rdy_oe_n), .drive(drive)
  );

  always_comb begin
    req.force_hi  = force_hi;
    req.busy      = tag_rd | tag_wr | stat_wr | clr_act;
    req.dedicated = ~generic_mode;
    req.cpu_wr    = cpu_wr;
    req.hit       = hit;
    req.vld       = vld;
    req.wt        = wt;
  end

  brdy_arbiter u_arb (
    .drive(drive), .ext_low(ext_low), .req(req), .src(src)
  );

  assign rdy_drv = (src != SRC_OFF);
  assign rdy_n   = ~src_is_low(src);
endmodule

// File: rtl/burst_ready_gen_chk.sv
module burst_ready_gen_chk #(
  parameter int N_LO       = 1,
  parameter int N_HI       = 1,
  parameter int EXT_STAGES = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_LO-1:0] cs_lo_n,
  input logic [N_HI-1:0] cs_hi,
  input logic            rdy_oe_n,
  input logic            ext_rdy_n,
  input logic            force_hi,
  input logic            tag_rd,
  input logic            tag_wr,
  input logic            stat_wr,
  input logic            clr_act,
  input logic            cpu_wr,
  input logic            generic_mode,
  input logic            hit,
  input logic            vld,
  input logic            wt,
  input logic            rdy_n,
  input logic            rdy_drv
);
  logic [EXT_STAGES-1:0] m;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m <= '1;
    else begin
      m[0] <= ext_rdy_n;
      for (int i = 1; i < EXT_STAGES; i++) m[i] <= m[i-1];
    end
  end

  logic quiet, busy, sel;
  assign quiet = m[EXT_STAGES-1];
  assign busy  = tag_rd | tag_wr | stat_wr | clr_act;
  assign sel   = !rdy_oe_n && !(|cs_lo_n) && (&cs_hi);

  // R1
  off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!rdy_drv && rdy_n));
  // R1
  on_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> rdy_drv);
  // R2
  ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_drv && !quiet) |-> !rdy_n);
  // R4
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_drv && quiet && force_hi) |-> rdy_n);
  // R5
  busy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_drv && quiet && busy) |-> rdy_n);
  // R6
  wthru_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_drv && quiet && !generic_mode && cpu_wr && wt) |-> rdy_n);
  // R7
  inval_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_drv && quiet && !generic_mode && !vld) |-> rdy_n);
  // R8
  ded_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_drv && quiet && !force_hi && !busy && !generic_mode &&
     !(cpu_wr && wt) && vld) |-> (rdy_n == !hit));
  // R9
  gen_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_drv && quiet && !force_hi && !busy && generic_mode) |-> (rdy_n == !hit));
endmodule

bind burst_ready_gen burst_ready_gen_chk #(
  .N_LO(N_LO), .N_HI(N_HI), .EXT_STAGES(EXT_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
  .rdy_oe_n(rdy_oe_n), .ext_rdy_n(ext_rdy_n), .force_hi(force_hi),
  .tag_rd(tag_rd), .tag_wr(tag_wr), .stat_wr(stat_wr), .clr_act(clr_act),
  .cpu_wr(cpu_wr), .generic_mode(generic_mode), .hit(hit), .vld(vld),
  .wt(wt), .rdy_n(rdy_n), .rdy_drv(rdy_drv)
);

// File: tb/sim_burst_ready_gen.sv
module sim_burst_ready_gen;
  localparam int N_LO = 2;
  localparam int N_HI = 1;
  localparam int EXT_STAGES = 2;
  localparam int NBITS = N_LO + N_HI + 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_LO-1:0] cs_lo_n = '0;
  logic [N_HI-1:0] cs_hi = '1;
  logic rdy_oe_n = 1'b0, ext_rdy_n = 1'b1, force_hi = 1'b0;
  logic tag_rd = 1'b0, tag_wr = 1'b0, stat_wr = 1'b0, clr_act = 1'b0;
  logic cpu_wr = 1'b0, generic_mode = 1'b0, hit = 1'b0, vld = 1'b0, wt = 1'b0;
  logic rdy_n, rdy_drv;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  burst_ready_gen #(.N_LO(N_LO), .N_HI(N_HI), .EXT_STAGES(EXT_STAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .rdy_oe_n(rdy_oe_n), .ext_rdy_n(ext_rdy_n), .force_hi(force_hi),
    .tag_rd(tag_rd), .tag_wr(tag_wr), .stat_wr(stat_wr), .clr_act(clr_act),
    .cpu_wr(cpu_wr), .generic_mode(generic_mode), .hit(hit), .vld(vld),
    .wt(wt), .rdy_n(rdy_n), .rdy_drv(rdy_drv)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // Expected strobe from the requirements; ext_seen = settled request is low.
  function automatic logic [1:0] model(input logic ext_seen);
    logic drv, lo;
    drv = !rdy_oe_n && (cs_lo_n == '0) && (&cs_hi);             // R1
    if (!drv) lo = 1'b0;
    else if (ext_seen) lo = 1'b1;                                // R2
    else if (force_hi) lo = 1'b0;                                // R4
    else if (tag_rd | tag_wr | stat_wr | clr_act) lo = 1'b0;     // R5
    else if (generic_mode) lo = hit;                             // R9
    else if (cpu_wr && wt) lo = 1'b0;                            // R6
    else if (!vld) lo = 1'b0;                                    // R7
    else lo = hit;                                               // R8
    return {drv, ~lo};
  endfunction

  task automatic set_miss();
    cs_lo_n = '0; cs_hi = '1; rdy_oe_n = 0; force_hi = 0;
    tag_rd = 0; tag_wr = 0; stat_wr = 0; clr_act = 0;
    cpu_wr = 0; generic_mode = 0; hit = 0; vld = 1; wt = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
      end
    end
  end

  initial begin
    logic [1:0] e;
    // R3: request low through reset
    set_miss();
    ext_rdy_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R3 reset drive", rdy_drv, 1'b1);
    chk("R3 reset strobe", rdy_n, 1'b1);
    rst_n = 1;
    ext_rdy_n = 1;
    #1;
    chk("R3 after release", rdy_n, 1'b1);
    @(posedge clk); #1;
    chk("R3 first edge", rdy_n, 1'b1);

    // R2: edge-by-edge arrival and withdrawal
    @(negedge clk); ext_rdy_n = 0; #1;
    chk("R2 before edge", rdy_n, 1'b1);
    @(posedge clk); #1;
    chk("R2 one edge", rdy_n, 1'b1);
    @(posedge clk); #1;
    chk("R2 two edges", rdy_n, 1'b0);
    @(negedge clk); ext_rdy_n = 1; #1;
    chk("R2 withdraw mid", rdy_n, 1'b0);
    @(posedge clk); #1;
    chk("R2 withdraw one edge", rdy_n, 1'b0);
    @(posedge clk); #1;
    chk("R2 withdraw two edges", rdy_n, 1'b1);

    // R6: write-through write, then back to read
    @(negedge clk); #1;
    hit = 1; vld = 1; wt = 1; cpu_wr = 1; #2;
    chk("R6 write-through write", rdy_n, 1'b1);
    cpu_wr = 0; #2;
    chk("R6 back to read", rdy_n, 1'b0);

    // Sweep R1 R2 R4 R5 R6 R7 R8 R9 under both settled request levels
    for (int x = 0; x < 2; x++) begin
      @(negedge clk);
      ext_rdy_n = x[0];
      repeat (EXT_STAGES) @(posedge clk);
      @(negedge clk); #1;
      for (int v = 0; v < (1 << NBITS); v++) begin
        {cs_lo_n, cs_hi, rdy_oe_n, force_hi, tag_rd, tag_wr, stat_wr,
         clr_act, cpu_wr, generic_mode, hit, vld, wt} = v[NBITS-1:0];
        #1;
        e = model(!x[0]);
        chk("R1 drive", rdy_drv, e[1]);
        chk("R2 R4 R5 R6 R7 R8 R9 strobe", rdy_n, e[0]);
        #1;
      end
    end
    finish_run();
  end
endmodule